// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that gives an external bus controller access to a bank of 256 eight-bit registers. It samples the SCL and SDA wires through synchronizer flip-flops clocked by a faster system clock, finds start and stop conditions, and answers only to one fixed 7-bit device address. The block never drives SDA high. It only pulls SDA low through an active-high output enable, and the board supplies the pull-up.

To write, the controller addresses the block with the write flag, sends one byte that becomes the register pointer, and then sends data bytes. Each data byte goes into the register at the pointer, and the pointer then steps by one. To read, the controller first runs a short write transfer that carries only the pointer and ends with a stop. It then opens a transfer with the read flag. The block returns bytes starting at the stored pointer and steps the pointer after each byte it sends.

A second port inside the chip can read and write every register directly. The pointer keeps its value between transfers.

Top module: `i2c_regfile_target`

## Requirements
- R1: A falling SDA while SCL is high is a start. A rising SDA while SCL is high is a stop. A start that arrives without a stop first (a repeated start) begins a new address phase, and the stored pointer is kept.
- R2: If the first byte after a start has 1101110 in bits 7:1, the block pulls SDA low for the ninth clock. Bit 0 selects the direction: 0x DC is a write and 0xDD is a read.
- R3: If the address does not match, the block does not acknowledge it. It then ignores every later byte until the next start, so nothing is written.
- R4: In a write transfer, the byte after the address loads the pointer. Each following byte is stored at the pointer, the pointer then increments, and every byte is acknowledged.
- R5: The pointer survives a stop. A read transfer returns the byte at the stored pointer first, with the most significant bit first.
- R6: During a read, each byte that the controller acknowledges is followed by the byte at the next pointer value.
- R7: After the controller answers a read byte with a not-acknowledge, the block leaves SDA released until the next start. The pointer has still advanced past the byte that was sent.
- R8: The pointer wraps from 0xFF to 0x00, for writes and for reads.
- R9: A stop in the middle of a byte aborts the transfer. The partial byte is not stored and the pointer does not change.
- R10: The internal port reads any register combinationally. A write strobe on that port stores a byte at the next clock edge. If both ports write in the same cycle, the bus write is the one that is kept.
- R11: After reset, SDA is released and every register reads 0x00.
- R12: The SDA enable changes only in the cycle after a detected SCL falling edge, a start or a stop. It therefore never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL wire as seen at the pad |
| sda_in | input | 1 | SDA wire as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| host_addr | input | 8 | Internal port register index |
| host_wr_en | input | 1 | Internal port write strobe |
| host_wr_data | input | 8 | Internal port write byte |
| host_rd_data | output | 8 | Register at host_addr, combinational |

## Verification
Every bus result arrives a fixed number of system cycles after the SCL edge that causes it. There are two synchronizer stages and one edge register, and the state register acts on the cycle after that. So an acknowledge or a read bit appears on SDA three cycles after SCL falls, and a stored byte can be read on the internal port four cycles after the eighth falling edge. The bench changes a wire only after a quarter-bit wait of ten cycles, and it samples SDA halfway through SCL high. It reads registers on the internal port only after the transfer's stop. Each sample is therefore taken well after its result is due and well before the next bus edge can disturb it.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;
    localparam int NREGS  = 1 << PTR_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } tgt_state_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic may_drive(tgt_state_t s);
        return (s == ST_ADDR_ACK) || (s == ST_PTR_ACK) ||
               (s == ST_WR_ACK)   || (s == ST_RD);
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t ev
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_chain;
    logic [LAST:0] sda_chain;
    logic          scl_q;
    logic          sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_in;
                    sda_chain <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[LAST-1:0], scl_in};
                    sda_chain <= {sda_chain[LAST-1:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_chain[LAST];
            sda_q <= sda_chain[LAST];
        end
    end

    always_comb begin
        ev.sda      = sda_chain[LAST];
        ev.scl_rise = scl_chain[LAST] & ~scl_q;
        ev.scl_fall = ~scl_chain[LAST] & scl_q;
        ev.start    = scl_chain[LAST] & scl_q & sda_q & ~sda_chain[LAST];
        ev.stop     = scl_chain[LAST] & scl_q & ~sda_q & sda_chain[LAST];
    end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [PTR_W-1:0]  bus_waddr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [PTR_W-1:0]  bus_raddr,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              host_we,
    input  logic [PTR_W-1:0]  host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata
);
    logic [BYTE_W-1:0] mem [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (bus_we) begin
            mem[bus_waddr] <= bus_wdata;
        end else if (host_we) begin
            mem[host_addr] <= host_wdata;
        end
    end

    assign bus_rdata  = mem[bus_raddr];
    assign host_rdata = mem[host_addr];

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101110
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          ev,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_stb,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    tgt_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rd_mode;
    logic              ack_ok;
    logic              addr_hit;

    assign addr_hit = (rx_sh[BYTE_W-1:1] == DEV_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr     <= '0;
            rd_mode <= 1'b0;
            ack_ok  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_byte <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WR: begin
                        if (ev.scl_rise && cnt != FULL) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    rd_mode <= rx_sh[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_PTR) begin
                                ptr    <= rx_sh;
                                sda_oe <= 1'b1;
                                state  <= ST_PTR_ACK;
                            end else begin
                                wr_stb  <= 1'b1;
                                wr_addr <= ptr;
                                wr_byte <= rx_sh;
                                ptr     <= ptr + 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            if (state == ST_ADDR_ACK && rd_mode) begin
                                tx_sh  <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                cnt    <= CNT_W'(1);
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                state  <= (state == ST_ADDR_ACK) ? ST_PTR : ST_WR;
                            end
                        end
                    end
                    ST_RD: begin
                        if (ev.scl_fall) begin
                            if (cnt == FULL) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                cnt    <= '0;
                                state  <= ST_RD_ACK;
                            end else begin
                                tx_sh  <= tx_sh << 1;
                                sda_oe <= ~tx_sh[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            ack_ok <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (ack_ok) begin
                                tx_sh  <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                cnt    <= CNT_W'(1);
                                state  <= ST_RD;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: SDA is pulled low only in an acknowledge slot or while sending read data
    a_r2_oe_only_when_owner: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> may_drive(state));

    // R1: a start always opens a fresh address phase with SDA released
    a_r1_start_opens_addr: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR) && (cnt == '0) && !sda_oe);

    // R9: a stop always returns to idle with SDA released
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE) && !sda_oe);

    // R3: a foreign address is left unacknowledged and the bus is ignored
    a_r3_foreign_addr: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && ev.scl_fall && cnt == FULL && !addr_hit && !ev.start && !ev.stop)
        |=> (state == ST_SKIP) && !sda_oe);

    // R8: the pointer has stepped by one (mod 256) when a byte is stored
    a_r8_ptr_step: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ptr == PTR_W'(wr_addr + 1'b1));

    // R4: every stored byte is acknowledged in the same cycle
    a_r4_store_acked: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> sda_oe);

    // R12: the SDA enable moves only just after an SCL fall, a start or a stop
    a_r12_oe_timing: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(ev.scl_fall || ev.start || ev.stop));

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101110,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_oe,
    input  logic [7:0]  host_addr,
    input  logic        host_wr_en,
    input  logic [7:0]  host_wr_data,
    output logic [7:0]  host_rd_data
);
    bus_evt_t          ev;
    logic [PTR_W-1:0]  ptr;
    logic              wr_stb;
    logic [PTR_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] rd_byte;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_byte (rd_byte),
        .ptr     (ptr),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_byte (wr_byte),
        .sda_oe  (sda_oe)
    );

    i2c_reg_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (wr_stb),
        .bus_waddr  (wr_addr),
        .bus_wdata  (wr_byte),
        .bus_raddr  (ptr),
        .bus_rdata  (rd_byte),
        .host_we    (host_wr_en),
        .host_addr  (host_addr),
        .host_wdata (host_wr_data),
        .host_rdata (host_rd_data)
    );

endmodule

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] host_addr = '0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_wr_data = '0;
    logic [7:0] host_rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    i2c_regfile_target u_dut (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl_drv),
        .sda_in       (sda_line),
        .sda_oe       (sda_oe),
        .host_addr    (host_addr),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rd_data (host_rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qwait();
        scl_drv = 1'b1; qwait();
        sda_drv = 1'b0; qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qwait();
        scl_drv = 1'b1; qwait();
        sda_drv = 1'b1; qwait();
    endtask

    task automatic bus_bit(input logic b);
        sda_drv = b;    qwait();
        scl_drv = 1'b1; qwait(); qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic bus_wr(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        sda_drv = 1'b1; qwait();
        scl_drv = 1'b1; qwait();
        acked = ~sda_line;
        qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic bus_rd(input logic give_ack, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            scl_drv = 1'b1; qwait();
            b[i] = sda_line;
            qwait();
            scl_drv = 1'b0;
        end
        qwait();
        sda_drv = ~give_ack; qwait();
        scl_drv = 1'b1; qwait(); qwait();
        scl_drv = 1'b0; qwait();
        sda_drv = 1'b1;
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wr_data = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rd_data;
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        bus_wr(8'hDC, a); check("R2 ptr-set addr ack", {7'd0, a}, 8'h01);
        bus_wr(p, a);     check("R4 ptr byte ack", {7'd0, a}, 8'h01);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R11 sda released", {7'd0, sda_oe}, 8'h00);
        host_rd(8'h00, d); check("R11 reg00 zero", d, 8'h00);
        host_rd(8'hFF, d); check("R11 regFF zero", d, 8'h00);
    endtask

    task automatic t_write_burst();
        logic a;
        logic [7:0] d;
        bus_start();
        bus_wr(8'hDC, a); check("R2 write addr ack (R12 timing)", {7'd0, a}, 8'h01);
        bus_wr(8'h20, a); check("R4 ptr ack", {7'd0, a}, 8'h01);
        bus_wr(8'h11, a); check("R4 data0 ack", {7'd0, a}, 8'h01);
        bus_wr(8'h22, a); check("R4 data1 ack", {7'd0, a}, 8'h01);
        bus_wr(8'h33, a); check("R4 data2 ack", {7'd0, a}, 8'h01);
        bus_stop();
        host_rd(8'h20, d); check("R4 reg20", d, 8'h11);
        host_rd(8'h21, d); check("R4 reg21", d, 8'h22);
        host_rd(8'h22, d); check("R4 reg22", d, 8'h33);
    endtask

    task automatic t_read_nack();
        logic a;
        logic [7:0] d;
        host_wr(8'h23, 8'h44);
        host_rd(8'h23, d); check("R10 host write", d, 8'h44);
        set_ptr(8'h21);
        bus_start();
        bus_wr(8'hDD, a); check("R2 read addr ack", {7'd0, a}, 8'h01);
        bus_rd(1'b1, d);  check("R5 first byte from stored ptr", d, 8'h22);
        bus_rd(1'b0, d);  check("R6 next byte", d, 8'h33);
        bus_rd(1'b0, d);  check("R7 released after nack", d, 8'hFF);
        bus_stop();
        bus_start();
        bus_wr(8'hDD, a); check("R2 read addr ack", {7'd0, a}, 8'h01);
        bus_rd(1'b0, d);  check("R7 ptr advanced past nacked byte", d, 8'h44);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic a;
        logic [7:0] d;
        bus_start();
        bus_wr(8'hDC, a);
        bus_wr(8'hFF, a);
        bus_wr(8'hA5, a);
        bus_wr(8'h5A, a); check("R8 byte after wrap acked", {7'd0, a}, 8'h01);
        bus_stop();
        host_rd(8'hFF, d); check("R8 regFF", d, 8'hA5);
        host_rd(8'h00, d); check("R8 reg00 after wrap", d, 8'h5A);
        set_ptr(8'hFF);
        bus_start();
        bus_wr(8'hDD, a);
        bus_rd(1'b1, d); check("R8 read FF", d, 8'hA5);
        bus_rd(1'b0, d); check("R8 read wraps to 00", d, 8'h5A);
        bus_stop();
    endtask

    task automatic t_repeated_start();
        logic a;
        logic [7:0] d;
        host_wr(8'h30, 8'h9C);
        bus_start();
        bus_wr(8'hDC, a);
        bus_wr(8'h30, a);
        bus_start();
        bus_wr(8'hDD, a); check("R1 repeated start addr ack", {7'd0, a}, 8'h01);
        bus_rd(1'b0, d);  check("R1 read after repeated start", d, 8'h9C);
        bus_stop();
    endtask

    task automatic t_foreign_addr();
        logic a;
        logic [7:0] d;
        bus_start();
        bus_wr(8'hA0, a); check("R3 no ack for foreign addr", {7'd0, a}, 8'h00);
        bus_wr(8'h10, a); check("R3 ignored byte not acked", {7'd0, a}, 8'h00);
        bus_wr(8'h77, a); check("R3 ignored data not acked", {7'd0, a}, 8'h00);
        bus_stop();
        host_rd(8'h10, d); check("R3 reg10 untouched", d, 8'h00);
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] d;
        host_wr(8'h40, 8'h3C);
        bus_start();
        bus_wr(8'hDC, a);
        bus_wr(8'h40, a);
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b0);
        bus_stop();
        host_rd(8'h40, d); check("R9 partial byte not stored", d, 8'h3C);
        bus_start();
        bus_wr(8'hDD, a); check("R9 idle after abort, addr ack", {7'd0, a}, 8'h01);
        bus_rd(1'b0, d);  check("R9 ptr unchanged by abort", d, 8'h3C);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_burst();
        t_read_nack();
        t_wrap();
        t_repeated_start();
        t_foreign_addr();
        t_abort();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule